// File: doc/BRIEF.md
# Framebuffer SRAM-to-FIFO Prefetcher

This block runs entirely on the fast system clock and moves one frame of 16-bit RGB565 pixels from a synchronous SRAM into the write side of a pixel FIFO. The FIFO is drained elsewhere by the display timing logic at a quarter of the system rate. The block owns the SRAM address, chip select and write enable during fetches. It captures read data after a fixed, parameterised latency and writes each returned word into the FIFO in the cycle it arrives.

A single linear counter walks the frame from address zero. A frame-start pulse restarts the walk at any time. Reads are throttled by the FIFO's reported free space minus the reads already in flight, so every word in the return pipeline has a slot waiting for it. After the last pixel has been read the block stays idle until the next frame-start pulse. A done flag marks the frame as complete once the final word has reached the FIFO.

Top module: `fb_prefetch`

## Requirements
- R1: While reset is held and right after it: sram_cs low, fifo_wr low, frame_done low, sram_we_n high, sram_addr zero.
- R2: The first read after a frame-start pulse uses address 0, in the cycle after the pulse. Each later read uses the previous read's address plus one. sram_addr bits above the counter width (bits 20:19 by default) are always zero.
- R3: The word on sram_rdata in the cycle RD_LAT cycles after a read is issued goes to fifo_wdata unchanged, with fifo_wr high in that same cycle. RGB565 fields (red 15:11, green 10:5, blue 4:0) pass through bit for bit, and words arrive in address order.
- R4: A read is issued only while fifo_free exceeds the number of reads in flight. The FIFO never receives a write while full. With no draining, a frame stops after exactly as many reads as there were free slots.
- R5: After FRAME_PIXELS reads in a frame, no further read is issued and sram_cs stays low until the next frame-start pulse.
- R6: sram_we_n is high on every cycle in which sram_cs is high.
- R7: A frame-start pulse during a fetch aborts it. fifo_wr is low in the pulse cycle. No word from a read issued before the pulse is ever written to the FIFO.
- R8: frame_done rises in the cycle after the final pixel's FIFO write. It stays high until a frame-start pulse, and is low from the cycle after that pulse.
- R9: sram_cs is low in any cycle where frame_start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that starts (or restarts) a frame fetch |
| fifo_free | input | FREE_W (8) | Free slots currently reported by the pixel FIFO |
| sram_rdata | input | 16 | SRAM read data, valid RD_LAT cycles after the address |
| sram_addr | output | ADDR_W (21) | SRAM word address |
| sram_cs | output | 1 | SRAM chip select, high for each read |
| sram_we_n | output | 1 | SRAM write enable, active low, held high |
| fifo_wdata | output | 16 | Pixel word to the FIFO (RGB565) |
| fifo_wr | output | 1 | FIFO write strobe |
| frame_done | output | 1 | Whole frame written to the FIFO |

## Verification
The delicate coincidence is a frame-start pulse landing in the same cycle as a read return, or while further returns from the old frame are still in the pipeline. The bench provokes this by waiting for a cycle with a read issued, then pulsing frame_start one cycle later and, in a second case, two cycles later. With a two-cycle latency, the second case puts a return exactly on the pulse cycle. The scoreboard is flushed and refilled with the new frame's pixels at the pulse, so any stale word reaching the FIFO shows up as a data mismatch or an unexpected write.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    // One pixel word as stored in the framebuffer.
    typedef struct packed {
        logic [4:0] red;
        logic [5:0] green;
        logic [4:0] blue;
    } rgb565_t;

    localparam int PIX_W = $bits(rgb565_t);

    // Per-slot tag travelling alongside an outstanding SRAM read.
    typedef struct packed {
        logic valid;
        logic last;
    } ret_tag_t;

endpackage

// File: rtl/fbp_addr_gen.sv
module fbp_addr_gen #(
    parameter int FRAME_PIXELS = 307200,
    parameter int CNT_W        = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trigger,
    input  logic             room_ok,
    output logic             issue,
    output logic             is_last,
    output logic [CNT_W-1:0] addr
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_PIXELS - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        issue   = active && room_ok && !trigger;
        is_last = issue && (cnt == LAST_IDX);
        addr    = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (trigger) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (issue) begin
            cnt <= cnt + CNT_W'(1);
            if (is_last) begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fbp_ret_pipe.sv
module fbp_ret_pipe
    import fbp_pkg::*;
#(
    parameter int RD_LAT = 2,
    parameter int FLT_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             issue,
    input  logic             is_last,
    output ret_tag_t         head,
    output logic [FLT_W-1:0] inflight
);

    ret_tag_t          stage [RD_LAT];
    logic [RD_LAT-1:0] vbits;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < RD_LAT; i++) begin
                stage[i] <= '0;
            end
        end else begin
            stage[0] <= '{valid: issue, last: is_last};
            for (int i = 1; i < RD_LAT; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    for (genvar g = 0; g < RD_LAT; g++) begin : g_vbits
        assign vbits[g] = stage[g].valid;
    end

    assign head     = stage[RD_LAT-1];
    assign inflight = FLT_W'($countones(vbits));

endmodule

// File: rtl/fbp_throttle.sv
module fbp_throttle #(
    parameter int FREE_W = 8,
    parameter int FLT_W  = 2
) (
    input  logic [FREE_W-1:0] fifo_free,
    input  logic [FLT_W-1:0]  inflight,
    output logic              room_ok
);

    logic [FREE_W-1:0] inflight_ext;

    assign inflight_ext = {{(FREE_W-FLT_W){1'b0}}, inflight};
    assign room_ok      = fifo_free > inflight_ext;

endmodule

// File: rtl/fb_prefetch.sv
module fb_prefetch
    import fbp_pkg::*;
#(
    parameter int FRAME_PIXELS = 307200,
    parameter int RD_LAT       = 2,
    parameter int ADDR_W       = 21,
    parameter int FREE_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic [15:0]       sram_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs,
    output logic              sram_we_n,
    output logic [15:0]       fifo_wdata,
    output logic              fifo_wr,
    output logic              frame_done
);

    localparam int CNT_W = $clog2(FRAME_PIXELS + 1);
    localparam int FLT_W = $clog2(RD_LAT + 1);

    logic             issue;
    logic             is_last;
    logic             room_ok;
    logic [CNT_W-1:0] cnt;
    logic [FLT_W-1:0] inflight;
    ret_tag_t         head;
    rgb565_t          pix;

    fbp_addr_gen #(
        .FRAME_PIXELS(FRAME_PIXELS),
        .CNT_W       (CNT_W)
    ) addr_gen_i (
        .clk    (clk),
        .rst    (rst),
        .trigger(frame_start),
        .room_ok(room_ok),
        .issue  (issue),
        .is_last(is_last),
        .addr   (cnt)
    );

    fbp_ret_pipe #(
        .RD_LAT(RD_LAT),
        .FLT_W (FLT_W)
    ) ret_pipe_i (
        .clk     (clk),
        .rst     (rst),
        .flush   (frame_start),
        .issue   (issue),
        .is_last (is_last),
        .head    (head),
        .inflight(inflight)
    );

    fbp_throttle #(
        .FREE_W(FREE_W),
        .FLT_W (FLT_W)
    ) throttle_i (
        .fifo_free(fifo_free),
        .inflight (inflight),
        .room_ok  (room_ok)
    );

    assign sram_addr  = {{(ADDR_W-CNT_W){1'b0}}, cnt};
    assign sram_cs    = issue;
    assign sram_we_n  = 1'b1;

    assign pix        = rgb565_t'(sram_rdata);
    assign fifo_wdata = pix;
    assign fifo_wr    = head.valid && !frame_start;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            frame_done <= 1'b0;
        end else if (fifo_wr && head.last) begin
            frame_done <= 1'b1;
        end
    end

endmodule

// File: rtl/fbp_prefetch_checks.sv
module fbp_prefetch_checks #(
    parameter int ADDR_W = 21,
    parameter int FREE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic [FREE_W-1:0] fifo_free,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs,
    input logic              fifo_wr,
    input logic              frame_done
);

    p_addr_first_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (sram_addr == '0));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        sram_cs |=> (!sram_cs || sram_addr == $past(sram_addr) + ADDR_W'(1)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (fifo_free != '0));

    p_idle_after_frame_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !sram_cs);

    p_no_write_on_trigger_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !fifo_wr);

    p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_done);

    p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame_start) |=> frame_done);

    p_no_read_on_trigger_r9: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !sram_cs);

endmodule

bind fb_prefetch fbp_prefetch_checks #(
    .ADDR_W(ADDR_W),
    .FREE_W(FREE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .fifo_free  (fifo_free),
    .sram_addr  (sram_addr),
    .sram_cs    (sram_cs),
    .fifo_wr    (fifo_wr),
    .frame_done (frame_done)
);

// File: tb/fb_prefetch_tb_top.sv
module fb_prefetch_tb_top;

    localparam int N      = 48;
    localparam int LAT    = 2;
    localparam int DEPTH  = 6;
    localparam int FREE_W = 8;
    localparam int ADDR_W = 21;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic              drain_en = 1'b0;
    logic [FREE_W-1:0] fifo_free;
    logic [15:0]       sram_rdata;
    logic [ADDR_W-1:0] sram_addr;
    logic              sram_cs;
    logic              sram_we_n;
    logic [15:0]       fifo_wdata;
    logic              fifo_wr;
    logic              frame_done;

    always #2 clk = ~clk;

    fb_prefetch #(
        .FRAME_PIXELS(N),
        .RD_LAT      (LAT),
        .ADDR_W      (ADDR_W),
        .FREE_W      (FREE_W)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .fifo_free  (fifo_free),
        .sram_rdata (sram_rdata),
        .sram_addr  (sram_addr),
        .sram_cs    (sram_cs),
        .sram_we_n  (sram_we_n),
        .fifo_wdata (fifo_wdata),
        .fifo_wr    (fifo_wr),
        .frame_done (frame_done)
    );

    int checks = 0;
    int fails  = 0;

    function automatic logic [15:0] pix_of(int a);
        return 16'((a * 40503 + 4660) ^ (a << 11));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // SRAM model with a fixed read latency
    logic [LAT-1:0]    sv;
    logic [ADDR_W-1:0] sa [LAT];

    always @(posedge clk) begin
        if (rst) begin
            sv <= '0;
            for (int i = 0; i < LAT; i++) sa[i] <= '0;
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                sv[i] <= sv[i-1];
                sa[i] <= sa[i-1];
            end
            sv[0] <= sram_cs;
            sa[0] <= sram_addr;
        end
    end

    assign sram_rdata = sv[LAT-1] ? pix_of(int'(sa[LAT-1])) : 16'hDEAD;

    // FIFO occupancy model, read side pops one word every fourth cycle
    int         fcount = 0;
    int         fmax   = 0;
    logic [1:0] tick   = '0;

    always @(posedge clk) begin
        if (rst) begin
            fcount <= 0;
            tick   <= '0;
        end else begin
            tick   <= tick + 2'd1;
            fcount <= fcount + (fifo_wr ? 1 : 0)
                    - ((drain_en && tick == 2'd3 && fcount > 0) ? 1 : 0);
        end
    end

    assign fifo_free = FREE_W'(DEPTH - fcount);

    // Scoreboard
    logic [15:0] exp_q[$];
    int          exp_addr = 0;
    int          reads    = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (fcount > fmax) fmax = fcount;
            if (frame_start) begin
                chk(!sram_cs, "R9", "read during trigger cycle", sram_cs, 0);
                chk(!fifo_wr, "R7", "write during trigger cycle", fifo_wr, 0);
                exp_addr = 0;
            end else begin
                if (sram_cs) begin
                    chk(sram_addr == ADDR_W'(exp_addr), "R2", "read address", sram_addr, exp_addr);
                    chk(sram_addr[ADDR_W-1:19] == '0, "R2", "upper address bits", sram_addr[ADDR_W-1:19], 0);
                    chk(sram_we_n, "R6", "write enable during read", sram_we_n, 1);
                    chk(exp_addr < N && !frame_done, "R5", "read past frame end", exp_addr, N - 1);
                    exp_addr++;
                    reads++;
                end
                if (fifo_wr) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected fifo write", fifo_wdata, 0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        chk(fifo_wdata == e, "R3", "fifo word", fifo_wdata, e);
                    end
                end
            end
        end
    end

    // Driver: pulse the trigger and load the expected frame
    task automatic start_frame();
        @(posedge clk);
        #1;
        frame_start = 1'b1;
        exp_q.delete();
        for (int i = 0; i < N; i++) exp_q.push_back(pix_of(i));
        reads = 0;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int n;
        n = 0;
        while (!frame_done && n < limit) begin
            @(posedge clk);
            n++;
        end
        #1;
    endtask

    task automatic end_of_frame_checks();
        @(negedge clk);
        chk(frame_done, "R8", "done after frame", frame_done, 1);
        chk(exp_q.size() == 0, "R3", "pixels left unwritten", exp_q.size(), 0);
        chk(reads == N, "R5", "reads in frame", reads, N);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!sram_cs, "R1", "cs in reset", sram_cs, 0);
        chk(!fifo_wr, "R1", "wr in reset", fifo_wr, 0);
        chk(!frame_done, "R1", "done in reset", frame_done, 0);
        chk(sram_we_n, "R1", "we_n in reset", sram_we_n, 1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!sram_cs && sram_addr == '0, "R1", "idle after reset", sram_addr, 0);

        // Plain frame with the reader draining
        drain_en = 1'b1;
        start_frame();
        wait_done(3000);
        end_of_frame_checks();
        repeat (20) @(negedge clk);
        chk(reads == N, "R5", "reads while idle", reads, N);
        chk(frame_done, "R8", "done holds while idle", frame_done, 1);

        // Backpressure: nothing drains, free slots bound the reads
        drain_en = 1'b0;
        start_frame();
        @(negedge clk);
        chk(!frame_done, "R8", "done cleared by trigger", frame_done, 0);
        repeat (40) @(negedge clk);
        chk(reads == DEPTH, "R4", "reads with stalled reader", reads, DEPTH);
        chk(fcount == DEPTH, "R4", "fifo fill with stalled reader", fcount, DEPTH);
        drain_en = 1'b1;
        wait_done(3000);
        end_of_frame_checks();

        // Abort with the trigger one cycle after a read
        start_frame();
        do @(negedge clk); while (!sram_cs);
        start_frame();
        wait_done(3000);
        end_of_frame_checks();

        // Abort with a return landing on the trigger cycle (R7)
        start_frame();
        do @(negedge clk); while (!sram_cs);
        @(posedge clk);
        start_frame();
        wait_done(3000);
        end_of_frame_checks();

        chk(fmax <= DEPTH, "R4", "peak fifo occupancy", fmax, DEPTH);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule